// File: doc/BRIEF.md
# Selectable-Source Edge-Aligned Clock Divider

This block picks one of two reference clocks and derives two slower clocks from it: one at half the source rate and one at a quarter of it. A select input chooses between a differential clock pair and a single-ended clock. Each divided clock comes out as a true output and its complementary output.

Both divided clocks come from one shared 2-bit counter, so their rising edges line up on the same source edge for as long as the block runs. An active-low asynchronous reset forces every true output low and every complementary output high, without waiting for a clock edge. Once reset is released, the first rising edge of the selected source drives both divided clocks high together.

The differential receiver reads a clock high only when the positive leg is high and the negative leg is low. An idle or unconnected pair, with the positive leg low and the negative leg high, therefore reads as a steady low.

Top module: `sel_clk_divider`

## Requirements
- R1: With srcSel = 0 the differential pair is the source (it reads high when diffClkP = 1 and diffClkN = 0). With srcSel = 1 the single-ended seClk is the source. Activity on the source that is not selected has no effect on the outputs.
- R2: After reset, outHalf toggles on every rising edge of the selected source.
- R3: Every rising edge of outQuarter falls on a source edge where outHalf also rises.
- R4: outQuarter changes level only on source edges where outHalf rises. It stays high for two source periods and low for two, so its period is four source periods.
- R5: While rstN = 0, outHalf = outQuarter = 0 and outHalfN = outQuarterN = 1. This takes effect asynchronously, with no source edge needed.
- R6: The first rising edge of the selected source after rstN rises drives outHalf and outQuarter both to 1.
- R7: outHalfN is always the inverse of outHalf, and outQuarterN is always the inverse of outQuarter, including during reset.
- R8: When the differential source is selected and the pair is idle (diffClkP = 0, diffClkN = 1), the source reads low and the outputs hold their reset values.
- R9: With a 100 MHz source, outHalf has a 20 ns period (50 MHz) and outQuarter has a 40 ns period (25 MHz).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| diffClkP | input | 1 | Differential reference clock, positive leg |
| diffClkN | input | 1 | Differential reference clock, negative leg |
| seClk | input | 1 | Single-ended reference clock |
| srcSel | input | 1 | Source select: 0 selects the differential pair, 1 selects seClk |
| rstN | input | 1 | Asynchronous reset, active low |
| outHalf | output | 1 | Clock at half the source rate, true output |
| outHalfN | output | 1 | Complement of outHalf |
| outQuarter | output | 1 | Clock at a quarter of the source rate, true output |
| outQuarterN | output | 1 | Complement of outQuarter |

## Verification
The assertions assume that srcSel changes only while rstN is low, because a switch between sources while running can produce a runt edge that breaks the toggle and alignment properties. They also assume that the differential legs are either complementary or parked in the idle state. The stimulus changes srcSel and the idle condition only inside reset windows, and drives the negative leg as the exact inverse of the positive leg. The clock that is not selected runs at an unrelated rate, so any leak from the unselected source into the outputs shows up as a mismatch.

// File: rtl/selclk_pkg.sv
`timescale 1ns/1ps
package selclk_pkg;
  // number of divided taps; tap i divides the source by 2**(i+1)
  localparam int NUM_TAPS = 2;
  localparam int CNT_W    = NUM_TAPS;

  // control-to-datapath strobe bundle: level each tap takes at the next edge
  typedef struct packed {
    logic [NUM_TAPS-1:0] tapLevel;
  } divStrobe_t;
endpackage

// File: rtl/clk_src_sel.sv
`timescale 1ns/1ps
module clk_src_sel (
  input  logic diffClkP,
  input  logic diffClkN,
  input  logic seClk,
  input  logic srcSel,
  output logic srcClk
);
  logic diffLevel;

  // an idle pair (P low, N high) resolves to a clean low
  assign diffLevel = diffClkP & ~diffClkN;
  assign srcClk    = srcSel ? seClk : diffLevel;
endmodule

// File: rtl/div_ctrl.sv
`timescale 1ns/1ps
module div_ctrl
  import selclk_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic       srcClk,
  input  logic       rstN,
  output divStrobe_t strobe
);
  localparam int W = TAPS;

  logic [W-1:0] phaseCnt;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else       phaseCnt <= phaseCnt + 1'b1;
  end

  // tap i is high for the next 2**i edges when bit i of the current phase is clear
  for (genvar i = 0; i < W; i++) begin : g_level
    assign strobe.tapLevel[i] = ~phaseCnt[i];
  end
endmodule

// File: rtl/div_path.sv
`timescale 1ns/1ps
module div_path
  import selclk_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic            srcClk,
  input  logic            rstN,
  input  divStrobe_t      strobe,
  output logic [TAPS-1:0] tapQ
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge srcClk or negedge rstN) begin
      if (!rstN) tapQ[i] <= 1'b0;
      else       tapQ[i] <= strobe.tapLevel[i];
    end
  end

  AST_HALF_TOGGLE: assert property (@(posedge srcClk) disable iff (!rstN)
    $past(rstN) |-> (tapQ[0] != $past(tapQ[0]))); // R2

  AST_RISE_ALIGN: assert property (@(posedge srcClk) disable iff (!rstN)
    $rose(tapQ[1]) |-> $rose(tapQ[0])); // R3

  AST_QUARTER_STEP: assert property (@(posedge srcClk) disable iff (!rstN)
    (tapQ[1] != $past(tapQ[1])) |-> $rose(tapQ[0])); // R4

  AST_FIRST_EDGE: assert property (@(posedge srcClk) disable iff (!rstN)
    !$past(rstN) |=> (&tapQ)); // R6
endmodule

// File: rtl/sel_clk_divider.sv
`timescale 1ns/1ps
module sel_clk_divider
  import selclk_pkg::*;
(
  input  logic diffClkP,
  input  logic diffClkN,
  input  logic seClk,
  input  logic srcSel,
  input  logic rstN,
  output logic outHalf,
  output logic outHalfN,
  output logic outQuarter,
  output logic outQuarterN
);
  logic                srcClk;
  divStrobe_t          strobe;
  logic [NUM_TAPS-1:0] tapQ;

  clk_src_sel u_sel (
    .diffClkP (diffClkP),
    .diffClkN (diffClkN),
    .seClk    (seClk),
    .srcSel   (srcSel),
    .srcClk   (srcClk)
  );

  div_ctrl #(.TAPS(NUM_TAPS)) u_ctrl (
    .srcClk (srcClk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  div_path #(.TAPS(NUM_TAPS)) u_path (
    .srcClk (srcClk),
    .rstN   (rstN),
    .strobe (strobe),
    .tapQ   (tapQ)
  );

  assign outHalf     = tapQ[0];
  assign outQuarter  = tapQ[1];
  assign outHalfN    = ~tapQ[0];
  assign outQuarterN = ~tapQ[1];

  AST_RESET_LEVELS: assert property (@(posedge srcClk)
    !rstN |-> (!outHalf && !outQuarter && outHalfN && outQuarterN)); // R5
endmodule

// File: tb/sel_clk_divider_test.sv
`timescale 1ns/1ps
module sel_clk_divider_test;
  logic clk = 1'b0;
  logic altClk = 1'b0;
  always #5 clk = ~clk;
  always #7 altClk = ~altClk;

  logic rstN, srcSel, idleDiff;
  logic outHalf, outHalfN, outQuarter, outQuarterN;

  wire diffDrive = srcSel ? altClk : clk;
  wire diffClkP  = idleDiff ? 1'b0 : diffDrive;
  wire diffClkN  = idleDiff ? 1'b1 : ~diffDrive;
  wire seClk     = srcSel ? clk : altClk;

  sel_clk_divider uut (
    .diffClkP    (diffClkP),
    .diffClkN    (diffClkN),
    .seClk       (seClk),
    .srcSel      (srcSel),
    .rstN        (rstN),
    .outHalf     (outHalf),
    .outHalfN    (outHalfN),
    .outQuarter  (outQuarter),
    .outQuarterN (outQuarterN)
  );

  int  checks = 0;
  int  fails  = 0;
  int  edges  = 0;
  bit  done   = 0;
  bit  cmpOn  = 0;
  bit  measure = 0;
  logic prevH = 1'b0;
  logic prevQ = 1'b0;
  time hRise[$];
  time qRise[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: count selected-source rising edges since reset
  always @(posedge clk or negedge rstN) begin
    if (!rstN) edges <= 0;
    else if (!idleDiff) edges <= edges + 1;
  end

  always @(posedge outHalf)    if (measure) hRise.push_back($time);
  always @(posedge outQuarter) if (measure) qRise.push_back($time);

  always @(negedge clk) begin
    if (cmpOn) begin
      logic eH, eQ;
      eH = (edges % 2) == 1;
      eQ = ((edges % 4) == 1) || ((edges % 4) == 2);
      check(outHalf === eH, "R2 half level", outHalf, eH);
      check(outQuarter === eQ, "R4 quarter level", outQuarter, eQ);
      check(outHalfN === ~outHalf && outQuarterN === ~outQuarter, "R7 complements",
            {outHalfN, outQuarterN}, {~outHalf, ~outQuarter});
      if (outQuarter && !prevQ)
        check(outHalf && !prevH, "R3 aligned rise", {prevH, outHalf}, 2'b01);
    end
    prevH <= outHalf;
    prevQ <= outQuarter;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b1; srcSel = 1'b0; idleDiff = 1'b0;
    #1 rstN = 1'b0;
    @(negedge clk);
    check(!outHalf && !outQuarter && outHalfN && outQuarterN, "R5 reset levels",
          {outHalf, outQuarter, outHalfN, outQuarterN}, 4'b0011);
    cmpOn = 1;

    // differential source running
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(outHalf && outQuarter, "R6 first edge high", {outHalf, outQuarter}, 2'b11);
    repeat (30) @(negedge clk);

    // asynchronous reset mid-cycle, no source edge in between
    #2 rstN = 1'b0;
    #1 check(!outHalf && !outQuarter && outHalfN && outQuarterN, "R5 async reset",
             {outHalf, outQuarter, outHalfN, outQuarterN}, 4'b0011);
    srcSel = 1'b1;

    // single-ended source, differential pair carries an unrelated clock
    @(negedge clk); measure = 1; rstN = 1'b1;
    repeat (40) @(negedge clk);
    measure = 0;
    check(hRise.size() == 20, "R1 single-ended source selected", hRise.size(), 20);
    check(hRise.size() > 2 && (hRise[2] - hRise[1]) == 20, "R9 half period 20ns",
          hRise.size() > 2 ? hRise[2] - hRise[1] : 0, 20);
    check(qRise.size() > 2 && (qRise[2] - qRise[1]) == 40, "R9 quarter period 40ns",
          qRise.size() > 2 ? qRise[2] - qRise[1] : 0, 40);

    // idle differential pair selected, single-ended clock still toggling
    @(negedge clk); rstN = 1'b0; srcSel = 1'b0; idleDiff = 1'b1;
    @(negedge clk); rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(!outHalf && !outQuarter && outHalfN && outQuarterN, "R8 idle pair holds",
          {outHalf, outQuarter, outHalfN, outQuarterN}, 4'b0011);
    check(!outHalf, "R1 unselected seClk ignored", outHalf, 0);

    done = 1;
    cmpOn = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule